// File: doc/BRIEF.md
# Interrupt Event State Coalescer

This block holds a two-bit state for each source in a small array of interrupt sources. One bit is P, the pending bit: the source has been forwarded to a downstream event queue and is waiting for end-of-interrupt (EOI). The other bit is Q, the re-trigger bit: another trigger arrived while P was set. Repeat triggers fold into Q, so each source has at most one entry outstanding in the queue. When EOI is performed, Q decides whether the source must be sent to the queue again.

Software controls the block through a memory-mapped load port. Each source owns a 4 KiB page. The offset inside the page selects the operation. Every load returns the state as it was before the operation, one cycle later, and the read and the change happen as one step. A store port performs EOI. A hardware trigger port triggers one source per cycle.

Forwarding requests wait in a pending set. They are issued on the notification port one per cycle, with the lowest source index first. A request is dropped if its source's P bit falls back to 0 before the request is issued.

Top module: `irq_pq_coalescer`

## Requirements
- R1: After reset every source holds PQ=00, `rd_valid_o` is low and `ntf_valid_o` is low.
- R2: Every load gets exactly one `rd_valid_o` pulse, in the cycle after the load. In the response, P is bit 1 (value 0x2), Q is bit 0 (value 0x1), and bits 63:2 are zero. The response carries the state that held before the load. A load at offset 0x800 returns the state and leaves it unchanged.
- R3: Loads at offsets 0xC00, 0xD00, 0xE00 and 0xF00 force PQ to 00, 01, 10 and 11 respectively.
- R4: EOI is performed by a load at offset 0x000 or by a store at offset 0x400. EOI takes state 10 to 00. EOI takes state 11 to 10 and raises a new notification. EOI leaves states 00 and 01 unchanged. A store at any other offset has no effect.
- R5: A hardware trigger takes state 00 to 10 and raises a notification. A trigger takes states 01, 10 and 11 to 11 and raises no notification.
- R6: A load whose offset has 0x40 added performs the same operation as the load without it. When a store EOI hits the same source in the same cycle, the order of the two depends on the 0x40 bit. A load with 0x40 added is applied after the store and returns the state the store left. A load without 0x40 is applied before the store.
- R7: When a hardware trigger and an access hit the same source in the same cycle, the access or accesses are applied first and the trigger is applied to the result.
- R8: A load to a source index of NUM_SRC or above returns 0x00000000000000FF and changes nothing. A load at an offset that decodes to no operation also returns 0xFF and changes nothing. Stores and triggers to source indexes of NUM_SRC or above are ignored.
- R9: Each raised notification appears as a one-cycle `ntf_valid_o` pulse carrying `ntf_src_o`. It appears no earlier than the cycle after the event that raised it. Pending notifications are issued one per cycle, lowest index first.
- R10: A notification that has not yet been issued is withdrawn if its source's P bit becomes 0. No notification is ever issued for a source whose P bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid_i | input | 1 | Load request this cycle |
| ld_addr_i | input | IDX_W+12 | Load address: source index above a 12-bit page offset |
| st_valid_i | input | 1 | Store request this cycle |
| st_addr_i | input | IDX_W+12 | Store address: source index above a 12-bit page offset |
| trg_valid_i | input | 1 | Hardware trigger this cycle |
| trg_src_i | input | IDX_W | Index of the triggered source |
| rd_valid_o | output | 1 | Load response valid |
| rd_data_o | output | 64 | Previous state of the addressed source, or 0xFF |
| ntf_valid_o | output | 1 | Notification toward the event queue |
| ntf_src_o | output | IDX_W | Source index of the notification |

## Verification
The assertions check several rules on every cycle. A load is always answered in the next cycle, and only then. A load to an unmapped source always returns 0xFF. A trigger always leaves P set. A plain read or a forced set gives the expected next state. A store EOI on state 10 clears it. An issued notification always belongs to a source whose P is set, and it leaves the pending set at once.

Only the bench scenarios can show the rest. These are the full transition table over every source, start state and offset, the two orderings of a load against a store in the same cycle, and a trigger merged with an access in the same cycle. They also cover the lowest-index-first issue order when three notifications are raised together, and the withdrawal of a queued notification after its source is cleared.

// File: rtl/pq_pkg.sv
`timescale 1ns/1ps
package pq_pkg;
  localparam int PAGE_BITS = 12;
  localparam int DATA_W    = 64;

  typedef logic [1:0] pq_t;
  localparam pq_t PQ_IDLE   = 2'b00;
  localparam pq_t PQ_OFF    = 2'b01;
  localparam pq_t PQ_PEND   = 2'b10;
  localparam pq_t PQ_RETRIG = 2'b11;

  localparam logic [PAGE_BITS-1:0] ORDER_BIT = 12'h040;
  localparam logic [PAGE_BITS-1:0] OFF_EOI_LD = 12'h000;
  localparam logic [PAGE_BITS-1:0] OFF_EOI_ST = 12'h400;
  localparam logic [PAGE_BITS-1:0] OFF_GET    = 12'h800;
  localparam logic [PAGE_BITS-1:0] OFF_SET00  = 12'hC00;
  localparam logic [PAGE_BITS-1:0] OFF_SET01  = 12'hD00;
  localparam logic [PAGE_BITS-1:0] OFF_SET10  = 12'hE00;
  localparam logic [PAGE_BITS-1:0] OFF_SET11  = 12'hF00;
  localparam logic [DATA_W-1:0]    RD_INVALID = 64'h0000_0000_0000_00FF;

  typedef enum logic [2:0] {
    OP_NONE, OP_EOI, OP_GET, OP_SET00, OP_SET01, OP_SET10, OP_SET11, OP_BAD
  } pq_op_e;

  typedef struct packed {
    logic fire;
    pq_t  pq;
  } pq_step_t;

  // Load offset to operation; the ordering bit does not change the operation.
  function automatic pq_op_e decode_load(input logic [PAGE_BITS-1:0] off);
    logic [PAGE_BITS-1:0] base;
    pq_op_e op;
    base = off & ~ORDER_BIT;
    case (base)
      OFF_EOI_LD: op = OP_EOI;
      OFF_GET:    op = OP_GET;
      OFF_SET00:  op = OP_SET00;
      OFF_SET01:  op = OP_SET01;
      OFF_SET10:  op = OP_SET10;
      OFF_SET11:  op = OP_SET11;
      default:    op = OP_BAD;
    endcase
    return op;
  endfunction

  function automatic logic is_ordered(input logic [PAGE_BITS-1:0] off);
    return (off & ORDER_BIT) != '0;
  endfunction

  function automatic logic is_store_eoi(input logic [PAGE_BITS-1:0] off);
    return off == OFF_EOI_ST;
  endfunction

  // One access applied to a state.
  function automatic pq_step_t apply_op(input pq_op_e op, input pq_t cur);
    pq_step_t r;
    r.fire = 1'b0;
    r.pq   = cur;
    case (op)
      OP_EOI: begin
        if (cur == PQ_PEND) r.pq = PQ_IDLE;
        else if (cur == PQ_RETRIG) begin
          r.pq   = PQ_PEND;
          r.fire = 1'b1;
        end
      end
      OP_SET00: r.pq = PQ_IDLE;
      OP_SET01: r.pq = PQ_OFF;
      OP_SET10: r.pq = PQ_PEND;
      OP_SET11: r.pq = PQ_RETRIG;
      default:  r.pq = cur;
    endcase
    return r;
  endfunction

  // Trigger: forward from idle, otherwise record a re-trigger.
  function automatic pq_step_t apply_trigger(input pq_t cur);
    pq_step_t r;
    r.fire = (cur == PQ_IDLE);
    r.pq   = (cur == PQ_IDLE) ? PQ_PEND : PQ_RETRIG;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] format_rd(input logic ok, input pq_t old);
    return ok ? {{(DATA_W-2){1'b0}}, old} : RD_INVALID;
  endfunction
endpackage

// File: rtl/pq_src_cell.sv
`timescale 1ns/1ps
module pq_src_cell
  import pq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  pq_op_e ld_op_i,
  input  logic   ld_after_st_i,
  input  logic   st_eoi_i,
  input  logic   trig_i,
  output pq_t    pq_o,
  output pq_t    ld_old_o,
  output logic   fire_o,
  output logic   p_next_o
);
  pq_t      pq_q;
  pq_op_e   op_first, op_second;
  pq_step_t first_s, second_s, trig_s;
  pq_op_e   st_op;

  assign st_op = st_eoi_i ? OP_EOI : OP_NONE;

  always_comb begin
    if (ld_after_st_i) begin
      op_first  = st_op;
      op_second = ld_op_i;
    end else begin
      op_first  = ld_op_i;
      op_second = st_op;
    end
    first_s  = apply_op(op_first, pq_q);
    second_s = apply_op(op_second, first_s.pq);
    if (trig_i) trig_s = apply_trigger(second_s.pq);
    else begin
      trig_s.fire = 1'b0;
      trig_s.pq   = second_s.pq;
    end
  end

  assign ld_old_o = ld_after_st_i ? first_s.pq : pq_q;
  assign fire_o   = first_s.fire | second_s.fire | trig_s.fire;
  assign p_next_o = trig_s.pq[1];
  assign pq_o     = pq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pq_q <= PQ_IDLE;
    else        pq_q <= trig_s.pq;
  end

  p_trig_sets_p_r5: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> pq_q[1]);
  p_set10_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_op_i == OP_SET10 && !st_eoi_i && !trig_i) |=> (pq_q == PQ_PEND));
  p_set01_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_op_i == OP_SET01 && !st_eoi_i && !trig_i) |=> (pq_q == PQ_OFF));
  p_get_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_op_i == OP_GET && !st_eoi_i && !trig_i) |=> $stable(pq_q));
  p_eoi_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_eoi_i && ld_op_i == OP_NONE && !trig_i && pq_q == PQ_PEND) |=> (pq_q == PQ_IDLE));
endmodule

// File: rtl/pq_ntf_sched.sv
`timescale 1ns/1ps
module pq_ntf_sched #(
  parameter int N     = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     set_i,
  input  logic [N-1:0]     keep_i,
  input  logic [N-1:0]     p_now_i,
  output logic             ntf_valid_o,
  output logic [IDX_W-1:0] ntf_src_o
);
  logic [N-1:0]     pend_q, pend_d, grant;
  logic [IDX_W-1:0] src_enc;

  always_comb begin
    grant   = pend_q & (~pend_q + N'(1));
    src_enc = '0;
    for (int i = 0; i < N; i++)
      if (grant[i]) src_enc = IDX_W'(i);
    pend_d = ((pend_q & ~grant) | set_i) & keep_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign ntf_valid_o = |pend_q;
  assign ntf_src_o   = src_enc;

  p_issue_has_p_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid_o |-> |(grant & p_now_i));
  p_issue_drains_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid_o && ((grant & set_i) == '0)) |=> ((pend_q & $past(grant)) == '0));
  p_one_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/irq_pq_coalescer.sv
`timescale 1ns/1ps
module irq_pq_coalescer
  import pq_pkg::*;
#(
  parameter int NUM_SRC = 12,
  parameter int IDX_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_valid_i,
  input  logic [IDX_W+PAGE_BITS-1:0] ld_addr_i,
  input  logic                       st_valid_i,
  input  logic [IDX_W+PAGE_BITS-1:0] st_addr_i,
  input  logic                       trg_valid_i,
  input  logic [IDX_W-1:0]           trg_src_i,
  output logic                       rd_valid_o,
  output logic [DATA_W-1:0]          rd_data_o,
  output logic                       ntf_valid_o,
  output logic [IDX_W-1:0]           ntf_src_o
);
  localparam int ADDR_W = IDX_W + PAGE_BITS;
  localparam logic [IDX_W:0] SRC_LIMIT = (IDX_W+1)'(NUM_SRC);

  logic [IDX_W-1:0]     ld_idx, st_idx;
  logic [PAGE_BITS-1:0] ld_off, st_off;
  logic                 ld_mapped, st_mapped, trg_mapped;
  pq_op_e               ld_op;
  logic                 ld_known, ld_ordered, st_hit, trg_hit;

  assign ld_idx     = ld_addr_i[ADDR_W-1:PAGE_BITS];
  assign ld_off     = ld_addr_i[PAGE_BITS-1:0];
  assign st_idx     = st_addr_i[ADDR_W-1:PAGE_BITS];
  assign st_off     = st_addr_i[PAGE_BITS-1:0];
  assign ld_mapped  = {1'b0, ld_idx} < SRC_LIMIT;
  assign st_mapped  = {1'b0, st_idx} < SRC_LIMIT;
  assign trg_mapped = {1'b0, trg_src_i} < SRC_LIMIT;
  assign ld_op      = decode_load(ld_off);
  assign ld_known   = ld_valid_i && ld_mapped && (ld_op != OP_BAD);
  assign ld_ordered = is_ordered(ld_off);
  assign st_hit     = st_valid_i && st_mapped && is_store_eoi(st_off);
  assign trg_hit    = trg_valid_i && trg_mapped;

  pq_t              pq_now [NUM_SRC];
  pq_t              ld_old [NUM_SRC];
  logic [NUM_SRC-1:0] fire_vec, p_next, p_now;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
    pq_op_e cell_op;
    assign cell_op  = (ld_known && ld_idx == IDX) ? ld_op : OP_NONE;
    assign p_now[i] = pq_now[i][1];
    pq_src_cell u_cell (
      .clk           (clk),
      .rst_n         (rst_n),
      .ld_op_i       (cell_op),
      .ld_after_st_i (ld_ordered),
      .st_eoi_i      (st_hit && st_idx == IDX),
      .trig_i        (trg_hit && trg_src_i == IDX),
      .pq_o          (pq_now[i]),
      .ld_old_o      (ld_old[i]),
      .fire_o        (fire_vec[i]),
      .p_next_o      (p_next[i])
    );
  end

  pq_t old_sel;
  always_comb begin
    old_sel = PQ_IDLE;
    for (int i = 0; i < NUM_SRC; i++)
      if (ld_idx == IDX_W'(i)) old_sel = ld_old[i];
  end

  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= ld_valid_i;
      if (ld_valid_i) rd_data_q <= format_rd(ld_known, old_sel);
    end
  end
  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  pq_ntf_sched #(.N(NUM_SRC), .IDX_W(IDX_W)) u_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (fire_vec),
    .keep_i      (p_next),
    .p_now_i     (p_now),
    .ntf_valid_o (ntf_valid_o),
    .ntf_src_o   (ntf_src_o)
  );

  p_rd_follows_ld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_i |=> rd_valid_o);
  p_rd_only_after_ld_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid_i |=> !rd_valid_o);
  p_unmapped_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid_i && !ld_mapped) |=> (rd_data_o == RD_INVALID));
endmodule

// File: tb/irq_pq_coalescer_bench.sv
`timescale 1ns/1ps
module irq_pq_coalescer_bench;
  localparam int NSRC = 12;
  localparam int IW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_valid = 1'b0, st_valid = 1'b0, trg_valid = 1'b0;
  logic [15:0] ld_addr = '0, st_addr = '0;
  logic [3:0]  trg_src = '0;
  logic        rd_valid, ntf_valid;
  logic [63:0] rd_data;
  logic [3:0]  ntf_src;

  always #2 clk = ~clk;

  irq_pq_coalescer #(.NUM_SRC(NSRC), .IDX_W(IW)) u_irq_pq_coalescer (
    .clk(clk), .rst_n(rst_n),
    .ld_valid_i(ld_valid), .ld_addr_i(ld_addr),
    .st_valid_i(st_valid), .st_addr_i(st_addr),
    .trg_valid_i(trg_valid), .trg_src_i(trg_src),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .ntf_valid_o(ntf_valid), .ntf_src_o(ntf_src)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [1:0]      m_pq [16];
  logic [NSRC-1:0] m_pend = '0;
  logic            exp_rv = 1'b0;
  logic [63:0]     exp_rd = '0;
  string           exp_tag = "R2";

  task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Bench codes: 0 EOI, 1 GET, 2..5 force 00..11, 6 undecoded offset.
  function automatic logic [11:0] code_off(input int code);
    if (code == 0) return 12'h000;
    if (code == 1) return 12'h800;
    if (code <= 5) return 12'(12'hC00 + (code - 2) * 12'h100);
    return 12'h100;
  endfunction

  // Returns {fire, next}.
  function automatic logic [2:0] m_access(input int code, input logic [1:0] s);
    if (code == 0) begin
      case (s)
        2'b10:   return 3'b0_00;
        2'b11:   return 3'b1_10;
        default: return {1'b0, s};
      endcase
    end
    if (code >= 2 && code <= 5) return {1'b0, 2'(code - 2)};
    return {1'b0, s};
  endfunction

  function automatic logic [2:0] m_trigger(input logic [1:0] s);
    if (s == 2'b00) return 3'b1_10;
    return 3'b0_11;
  endfunction

  // Compare outputs, then drive one cycle of stimulus and advance the model.
  task automatic drive(input logic ld, input int lidx, input int lcode, input logic lord,
                       input logic st, input int sidx, input logic [11:0] soff,
                       input logic tr, input int tidx, input string tag);
    logic [NSRC-1:0] pend_n, low;
    int lowi;
    @(negedge clk);
    check(exp_tag, "rd_valid", 64'(rd_valid), 64'(exp_rv));
    if (exp_rv) check(exp_tag, "rd_data", rd_data, exp_rd);
    lowi = -1;
    for (int i = NSRC - 1; i >= 0; i--) if (m_pend[i]) lowi = i;
    check(tag == "" ? "R9" : tag, "ntf_valid", 64'(ntf_valid), 64'(lowi >= 0));
    if (lowi >= 0) check(tag == "" ? "R9" : tag, "ntf_src", 64'(ntf_src), 64'(lowi));
    ld_valid  = ld;
    ld_addr   = {4'(lidx), code_off(lcode) | (lord ? 12'h040 : 12'h000)};
    st_valid  = st;
    st_addr   = {4'(sidx), soff};
    trg_valid = tr;
    trg_src   = 4'(tidx);
    low = '0;
    if (lowi >= 0) low[lowi] = 1'b1;
    pend_n = m_pend & ~low;
    exp_rv  = ld;
    exp_rd  = 64'hFF;
    exp_tag = (tag == "") ? "R2" : tag;
    for (int i = 0; i < NSRC; i++) begin
      logic [1:0] s;
      logic [2:0] r;
      logic       fire, hl, hs;
      s = m_pq[i];
      fire = 1'b0;
      hl = ld && lidx == i && lcode != 6;
      hs = st && sidx == i && soff == 12'h400;
      if (hl && lord) begin
        if (hs) begin r = m_access(0, s); fire |= r[2]; s = r[1:0]; end
        exp_rd = {62'b0, s};
        r = m_access(lcode, s); fire |= r[2]; s = r[1:0];
      end else begin
        if (hl) begin
          exp_rd = {62'b0, s};
          r = m_access(lcode, s); fire |= r[2]; s = r[1:0];
        end
        if (hs) begin r = m_access(0, s); fire |= r[2]; s = r[1:0]; end
      end
      if (tr && tidx == i) begin r = m_trigger(s); fire |= r[2]; s = r[1:0]; end
      m_pq[i] = s;
      if (fire) pend_n[i] = 1'b1;
      if (!s[1]) pend_n[i] = 1'b0;
    end
    m_pend = pend_n;
  endtask

  task automatic do_load(input int idx, input int code, input logic ord, input string tag);
    drive(1'b1, idx, code, ord, 1'b0, 0, 12'h0, 1'b0, 0, tag);
  endtask
  task automatic do_store(input int idx, input logic [11:0] off, input string tag);
    drive(1'b0, 0, 1, 1'b0, 1'b1, idx, off, 1'b0, 0, tag);
  endtask
  task automatic do_trig(input int idx, input string tag);
    drive(1'b0, 0, 1, 1'b0, 1'b0, 0, 12'h0, 1'b1, idx, tag);
  endtask
  task automatic idle(input string tag);
    drive(1'b0, 0, 1, 1'b0, 1'b0, 0, 12'h0, 1'b0, 0, tag);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_pq[i] = 2'b00;
    repeat (3) @(negedge clk);
    check("R1", "rd_valid in reset", 64'(rd_valid), 64'd0);
    check("R1", "ntf_valid in reset", 64'(ntf_valid), 64'd0);
    rst_n = 1'b1;
    // R1: every source reads 00 after reset
    for (int s = 0; s < NSRC; s++) do_load(s, 1, 1'b0, "R1");

    // Load sweep: every source (mapped and not), start state, offset, ordering bit
    for (int s = 0; s < 16; s++)
      for (int init = 0; init < 4; init++)
        for (int code = 0; code < 7; code++)
          for (int ord = 0; ord < 2; ord++) begin
            string t;
            if (s >= NSRC || code == 6) t = "R8";
            else if (ord == 1)          t = "R6";
            else if (code == 0)         t = "R4";
            else if (code == 1)         t = "R2";
            else                        t = "R3";
            do_load(s, 2 + init, 1'b0, t);
            do_load(s, code, ord[0], t);
            do_load(s, 1, 1'b0, t);
          end

    // R5: trigger from each state
    for (int s = 0; s < 16; s++)
      for (int init = 0; init < 4; init++) begin
        do_load(s, 2 + init, 1'b0, "R5");
        do_trig(s, "R5");
        do_load(s, 1, 1'b0, "R5");
        idle("R5");
      end

    // R4: store EOI, and stores at other offsets ignored
    for (int s = 0; s < 16; s++)
      for (int init = 0; init < 4; init++) begin
        do_load(s, 2 + init, 1'b0, "R4");
        do_store(s, 12'h800, "R4");
        do_load(s, 1, 1'b0, "R4");
        do_store(s, 12'h400, "R4");
        do_load(s, 1, 1'b0, "R4");
        idle("R4");
      end

    // R6 / R7: load, store and trigger on one source in one cycle
    for (int init = 0; init < 4; init++)
      for (int code = 0; code < 7; code++)
        for (int ord = 0; ord < 2; ord++)
          for (int st = 0; st < 2; st++)
            for (int tr = 0; tr < 2; tr++) begin
              string t;
              t = (tr == 1) ? "R7" : "R6";
              do_load(3, 2 + init, 1'b0, t);
              drive(1'b1, 3, code, ord[0], st[0], 3, 12'h400, tr[0], 3, t);
              do_load(3, 1, 1'b0, t);
              idle(t);
            end

    // R9: three notifications raised together, issued lowest index first
    do_load(1, 2, 1'b0, "R9");
    do_load(2, 5, 1'b0, "R9");
    do_load(5, 5, 1'b0, "R9");
    idle("R9");
    drive(1'b1, 5, 0, 1'b0, 1'b1, 2, 12'h400, 1'b1, 1, "R9");
    repeat (4) idle("R9");

    // R10: queued notification withdrawn when its source is cleared
    do_load(1, 2, 1'b0, "R10");
    do_load(2, 5, 1'b0, "R10");
    do_load(5, 5, 1'b0, "R10");
    idle("R10");
    drive(1'b1, 5, 0, 1'b0, 1'b1, 2, 12'h400, 1'b1, 1, "R10");
    do_load(5, 2, 1'b0, "R10");
    repeat (4) idle("R10");

    summary();
    $finish;
  end
endmodule